// File: doc/BRIEF.md
# PCM to IEC-60958 Subframe Packer

This block sits in front of an HDMI audio FIFO and turns a stream of interleaved audio words into packed 32-bit subframes. Each output word holds the sample in its low 24 bits, and above the sample the flag nibble for validity, user, channel-status and parity. Bit 28 marks the start of a 192-frame channel-status block. Words arrive and leave on valid/ready stream ports, one subframe per channel per frame, with the channels in order.

There are two input formats. In raw PCM format the packer inserts the channel-status bit itself. A 192-frame sequencer supplies that bit from a 32-bit consumer status seed, and each channel's copy of the seed carries that channel's own number. The packer also computes even parity and sets the block-start flag. In pre-formatted format the input is already a complete subframe whose fields sit four bits higher, and the packer only moves the fields down.

A one-cycle `start_i` pulse clears the sequencer and discards any word held at the output. On the same edge it takes the format, the channel count and the seed, and keeps them until the next pulse.

Top module: `iec_subframe_packer`

## Requirements
- R1: With `fmt_i`=0 (raw PCM), output bits 23..0 equal input bits 23..0, and input bits 31..24 have no effect on the output.
- R2: In raw PCM format, output bits 25 (user) and 24 (validity) are 0, and output bits 31..29 are 0.
- R3: In raw PCM format, output bit 27 is set exactly when output bits 26..0 hold an odd number of ones, so that bits 27..0 carry even parity.
- R4: The channel index runs 0 to N-1 over the subframes of a frame. The frame index advances by one after the subframe of channel N-1 and wraps from 191 to 0.
- R5: In raw PCM format, output bit 26 of frame f equals bit f of the sampled seed for f below 32, except for frames 20 to 23. Seed byte b occupies seed bits 8b+7..8b and is sent LSB first. Frames 32 to 191 send a 0.
- R6: In frames 20 to 23, output bit 26 of channel c is bit (f-20) of the value c+1. This replaces the upper nibble of status byte 2 with the channel number.
- R7: In raw PCM format, output bit 28 is 1 on the subframe of channel 0 in frame 0 and 0 on every other subframe.
- R8: The channel count N is taken from `nch_i`. A value below 2 is used as 2, and a value above 8 is used as 8.
- R9: With `fmt_i`=1 (pre-formatted), output bits 27..0 equal input bits 31..4, output bit 28 equals input bit 3, and output bits 31..29 are 0.
- R10: During a cycle with `start_i`=1, `s_ready_o` is 0. After that cycle the held output word is discarded and the next accepted word is channel 0 of frame 0. The format, count and seed are sampled at that start, and later changes to `fmt_i`, `nch_i` and `cs_seed_i` have no effect until the next start.
- R11: While `m_valid_o`=1 and `m_ready_i`=0, `m_data_o` holds its value. No accepted word is lost or repeated, and with `m_ready_i`=1 one word passes per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Synchronous clear and configuration capture |
| fmt_i | input | 1 | Input format: 0 raw PCM, 1 pre-formatted subframe |
| nch_i | input | 4 | Channels per frame (clamped to 2..8) |
| cs_seed_i | input | 32 | Consumer channel-status seed, byte 0 in bits 7..0 |
| s_valid_i | input | 1 | Input word valid |
| s_data_i | input | 32 | Input word |
| s_ready_o | output | 1 | Input word accepted when high with valid |
| m_valid_o | output | 1 | Output subframe valid |
| m_data_o | output | 32 | Packed output subframe |
| m_ready_i | input | 1 | Downstream ready |

## Verification
A channel-status block wraps from frame 191 to frame 0 on the same subframe that must carry the block-start flag. That subframe can arrive while the output is stalled, so the sequencer advance and the output hold fall in the same cycle. Sweeps for every channel count run across two full block wraps with random valid and random ready. Each output is judged against the bench's own count of accepted words, so a counter that advances on a stalled cycle shows up as a wrong frame, channel or flag. A start pulse is also issued while a word sits unaccepted at the output, and the bench then checks that the word is gone and that the first new subframe carries the block-start flag.

// File: rtl/iecpk_pkg.sv
// Shared definitions for the IEC-60958 subframe packer.
// Assumes a 32-bit output word with the flag nibble directly above a
// 24-bit sample and the block-start flag directly above the flags.
package iecpk_pkg;

    typedef enum logic {
        FMT_PCM = 1'b0,
        FMT_PRE = 1'b1
    } fmt_e;

    localparam int SAMPLE_W    = 24;
    localparam int POS_VALID   = 24;
    localparam int POS_USER    = 25;
    localparam int POS_CSTAT   = 26;
    localparam int POS_PARITY  = 27;
    localparam int POS_BLOCK   = 28;

    // Channel-number field inside each channel's status copy (upper nibble of byte 2)
    localparam int CHNUM_LSB   = 20;
    localparam int CHNUM_W     = 4;

    // Pre-formatted input layout
    localparam int PRE_SHIFT   = 4;
    localparam int PRE_BLK_SRC = 3;

endpackage

// File: rtl/iecpk_seq.sv
// Frame/channel sequencer.
// Counts accepted subframes: a channel index cycles 0..n_ch-1 and a frame
// index advances after the last channel, wrapping at BLOCK_FRAMES.
// Assumes n_ch_i lies in 1..MAX_CH and changes only together with clear_i.
module iecpk_seq #(
    parameter int MAX_CH       = 8,
    parameter int BLOCK_FRAMES = 192,
    localparam int CH_W        = $clog2(MAX_CH),
    localparam int NCH_W       = $clog2(MAX_CH + 1),
    localparam int FR_W        = $clog2(BLOCK_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             advance_i,
    input  logic [NCH_W-1:0] n_ch_i,
    output logic [CH_W-1:0]  ch_o,
    output logic [FR_W-1:0]  frame_o
);

    logic [CH_W-1:0] ch_q;
    logic [FR_W-1:0] fr_q;
    logic            ch_last;
    logic            fr_last;

    // Decode the end of a frame and the end of a block
    always_comb begin
        ch_last = (NCH_W'(ch_q) + NCH_W'(1)) == n_ch_i;
        fr_last = fr_q == FR_W'(BLOCK_FRAMES - 1);
    end

    // Step the channel and frame counters once per accepted subframe
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            ch_q <= '0;
            fr_q <= '0;
        end else if (advance_i) begin
            if (ch_last) begin
                ch_q <= '0;
                fr_q <= fr_last ? '0 : fr_q + FR_W'(1);
            end else begin
                ch_q <= ch_q + CH_W'(1);
            end
        end
    end

    assign ch_o    = ch_q;
    assign frame_o = fr_q;

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !clear_i && ch_last && fr_last) |=> (fr_q == '0 && ch_q == '0)); // R4

    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q < FR_W'(BLOCK_FRAMES)); // R4

    AST_CH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        NCH_W'(ch_q) < n_ch_i); // R8

endmodule

// File: rtl/iecpk_cs_sel.sv
// Channel-status bit selector.
// Builds one status copy per channel from the seed, with the channel number
// (plus one) written into the channel-number field, and picks the bit for
// the current frame. Frames at or beyond STATUS_BITS carry zero.
// Also flags the first subframe of a block. Purely combinational.
module iecpk_cs_sel
    import iecpk_pkg::*;
#(
    parameter int MAX_CH       = 8,
    parameter int BLOCK_FRAMES = 192,
    parameter int STATUS_BITS  = 32,
    localparam int CH_W        = $clog2(MAX_CH),
    localparam int FR_W        = $clog2(BLOCK_FRAMES),
    localparam int SB_W        = $clog2(STATUS_BITS)
) (
    input  logic [STATUS_BITS-1:0] seed_i,
    input  logic [CH_W-1:0]        ch_i,
    input  logic [FR_W-1:0]        frame_i,
    output logic                   cs_bit_o,
    output logic                   blk_o
);

    localparam logic [STATUS_BITS-1:0] FIELD_MASK =
        STATUS_BITS'(((1 << CHNUM_W) - 1) << CHNUM_LSB);

    logic [STATUS_BITS-1:0] chan_word [MAX_CH];

    // One status copy per channel, differing only in the channel-number field
    for (genvar c = 0; c < MAX_CH; c++) begin : g_chan
        assign chan_word[c] = (seed_i & ~FIELD_MASK) |
                              (STATUS_BITS'(c + 1) << CHNUM_LSB);
    end

    // Pick the status bit for this frame and flag the block start
    always_comb begin
        if (frame_i < FR_W'(STATUS_BITS))
            cs_bit_o = chan_word[ch_i][frame_i[SB_W-1:0]];
        else
            cs_bit_o = 1'b0;
        blk_o = (frame_i == '0) && (ch_i == '0);
    end

endmodule

// File: rtl/iecpk_fmt.sv
// Subframe formatter.
// Raw PCM: keeps the 24-bit sample, inserts the channel-status bit and even
// parity, leaves user/validity at zero and sets the block flag as told.
// Pre-formatted: shifts the fields down and moves the block-start preamble
// bit into the block flag position. Purely combinational.
module iecpk_fmt
    import iecpk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fmt_e              fmt_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              cs_bit_i,
    input  logic              blk_i,
    output logic [DATA_W-1:0] dout_o
);

    // Build the packed word for the selected input format
    always_comb begin
        dout_o = '0;
        if (fmt_i == FMT_PCM) begin
            dout_o[SAMPLE_W-1:0] = din_i[SAMPLE_W-1:0];
            dout_o[POS_CSTAT]    = cs_bit_i;
            dout_o[POS_PARITY]   = ^{cs_bit_i, din_i[SAMPLE_W-1:0]};
            dout_o[POS_USER]     = 1'b0;
            dout_o[POS_VALID]    = 1'b0;
            dout_o[POS_BLOCK]    = blk_i;
        end else begin
            dout_o = DATA_W'(din_i >> PRE_SHIFT);
            dout_o[POS_BLOCK] = din_i[PRE_BLK_SRC];
        end
    end

endmodule

// File: rtl/iecpk_out_stage.sv
// Output register with valid/ready.
// Holds one word; accepts a new word when empty or when the held word is
// leaving in the same cycle, so a ready sink sees one word per cycle.
// A flush empties the register and blocks acceptance in that cycle.
module iecpk_out_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    input  logic              out_ready_i
);

    logic              vld_q;
    logic [DATA_W-1:0] dat_q;
    logic              take;

    // Accept when not flushing and the slot is free or draining
    always_comb begin
        in_ready_o = !flush_i && (!vld_q || out_ready_i);
        take       = in_valid_i && in_ready_o;
    end

    // Track occupancy of the output slot
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i)
            vld_q <= 1'b0;
        else if (take)
            vld_q <= 1'b1;
        else if (out_ready_i)
            vld_q <= 1'b0;
    end

    // Capture the word on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)
            dat_q <= '0;
        else if (take)
            dat_q <= in_data_i;
    end

    assign out_valid_o = vld_q;
    assign out_data_o  = dat_q;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !out_ready_i && !flush_i) |=> (vld_q && $stable(dat_q))); // R11

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !vld_q); // R10

endmodule

// File: rtl/iec_subframe_packer.sv
// PCM to IEC-60958 subframe packer (top).
// Captures format, channel count (clamped to MIN_CH..MAX_CH) and status
// seed on start_i, sequences frames/channels over accepted words, formats
// each word and registers it at the output. Assumes start_i is a
// synchronous pulse; input words are not accepted while it is high.
module iec_subframe_packer
    import iecpk_pkg::*;
#(
    parameter int MAX_CH       = 8,
    parameter int MIN_CH       = 2,
    parameter int BLOCK_FRAMES = 192,
    parameter int STATUS_BITS  = 32,
    parameter int DATA_W       = 32,
    localparam int NCH_W       = $clog2(MAX_CH + 1),
    localparam int CH_W        = $clog2(MAX_CH),
    localparam int FR_W        = $clog2(BLOCK_FRAMES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   fmt_i,
    input  logic [NCH_W-1:0]       nch_i,
    input  logic [STATUS_BITS-1:0] cs_seed_i,
    input  logic                   s_valid_i,
    input  logic [DATA_W-1:0]      s_data_i,
    output logic                   s_ready_o,
    output logic                   m_valid_o,
    output logic [DATA_W-1:0]      m_data_o,
    input  logic                   m_ready_i
);

    fmt_e                   fmt_q;
    logic [NCH_W-1:0]       nch_q;
    logic [NCH_W-1:0]       nch_clamped;
    logic [STATUS_BITS-1:0] seed_q;
    logic [CH_W-1:0]        ch_idx;
    logic [FR_W-1:0]        fr_idx;
    logic                   cs_bit;
    logic                   blk_flag;
    logic [DATA_W-1:0]      packed_word;
    logic                   accept;

    // Limit the requested channel count to the supported range
    always_comb begin
        if (nch_i < NCH_W'(MIN_CH))
            nch_clamped = NCH_W'(MIN_CH);
        else if (nch_i > NCH_W'(MAX_CH))
            nch_clamped = NCH_W'(MAX_CH);
        else
            nch_clamped = nch_i;
    end

    // Hold the stream configuration from one start to the next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= FMT_PCM;
            nch_q  <= NCH_W'(MIN_CH);
            seed_q <= '0;
        end else if (start_i) begin
            fmt_q  <= fmt_e'(fmt_i);
            nch_q  <= nch_clamped;
            seed_q <= cs_seed_i;
        end
    end

    assign accept = s_valid_i && s_ready_o;

    iecpk_seq #(
        .MAX_CH       (MAX_CH),
        .BLOCK_FRAMES (BLOCK_FRAMES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (start_i),
        .advance_i (accept),
        .n_ch_i    (nch_q),
        .ch_o      (ch_idx),
        .frame_o   (fr_idx)
    );

    iecpk_cs_sel #(
        .MAX_CH       (MAX_CH),
        .BLOCK_FRAMES (BLOCK_FRAMES),
        .STATUS_BITS  (STATUS_BITS)
    ) u_cs (
        .seed_i   (seed_q),
        .ch_i     (ch_idx),
        .frame_i  (fr_idx),
        .cs_bit_o (cs_bit),
        .blk_o    (blk_flag)
    );

    iecpk_fmt #(
        .DATA_W (DATA_W)
    ) u_fmt (
        .fmt_i    (fmt_q),
        .din_i    (s_data_i),
        .cs_bit_i (cs_bit),
        .blk_i    (blk_flag),
        .dout_o   (packed_word)
    );

    iecpk_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (start_i),
        .in_valid_i  (s_valid_i),
        .in_data_i   (packed_word),
        .in_ready_o  (s_ready_o),
        .out_valid_o (m_valid_o),
        .out_data_o  (m_data_o),
        .out_ready_i (m_ready_i)
    );

    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && fmt_q == FMT_PCM) |-> (^m_data_o[POS_PARITY:0] == 1'b0)); // R3

    AST_UV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && fmt_q == FMT_PCM) |->
        (m_data_o[POS_USER:POS_VALID] == 2'b00 && m_data_o[DATA_W-1:POS_BLOCK+1] == '0)); // R2

    AST_PRE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid_o && fmt_q == FMT_PRE) |-> (m_data_o[DATA_W-1:POS_BLOCK+1] == '0)); // R9

    AST_NO_TAKE_IN_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_ready_o); // R10

endmodule

// File: tb/sim_iec_subframe_packer.sv
// Self-checking bench: sweeps every channel count over two block wraps
// with random valid and backpressure, plus clamp, pre-formatted and
// start-flush cases. Expected words are computed from the word index.
module sim_iec_subframe_packer;

    localparam int LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        fmt_i = 1'b0;
    logic [3:0]  nch_i = 4'd2;
    logic [31:0] cs_seed_i = '0;
    logic        s_valid_i = 1'b0;
    logic [31:0] s_data_i = '0;
    logic        s_ready_o;
    logic        m_valid_o;
    logic [31:0] m_data_o;
    logic        m_ready_i = 1'b0;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;
    logic        timed_out = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    iec_subframe_packer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .fmt_i     (fmt_i),
        .nch_i     (nch_i),
        .cs_seed_i (cs_seed_i),
        .s_valid_i (s_valid_i),
        .s_data_i  (s_data_i),
        .s_ready_o (s_ready_o),
        .m_valid_o (m_valid_o),
        .m_data_o  (m_data_o),
        .m_ready_i (m_ready_i)
    );

    function automatic logic [31:0] next_rng(logic [31:0] x);
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    function automatic logic [31:0] word_of(int unsigned k, logic [31:0] salt);
        logic [31:0] x;
        x = k * 32'h9E37_79B1 + salt;
        x = x ^ (x >> 15);
        x = x * 32'h85EB_CA6B;
        x = x ^ (x >> 13);
        return x;
    endfunction

    task automatic chk(string tag, int unsigned k, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: word %0d actual %h expected %h", tag, k, got, exp);
        end
    endtask

    // Check one output word against the value derived from its index
    task automatic judge(bit pre, int n, logic [31:0] seed, logic [31:0] salt,
                         int unsigned k, logic [31:0] got, bit clamp_run);
        logic [31:0] din;
        int ch;
        int fr;
        logic cs;
        logic par;
        logic blk;
        din = word_of(k, salt);
        if (pre) begin
            chk("R9", k, got, {3'b000, din[3], din[31:4]});
        end else begin
            ch = k % n;
            fr = (k / n) % 192;
            if (fr >= 20 && fr <= 23)
                cs = ((ch + 1) >> (fr - 20)) & 1;
            else if (fr < 32)
                cs = seed[fr];
            else
                cs = 1'b0;
            par = ^{cs, din[23:0]};
            blk = (fr == 0 && ch == 0);
            chk("R1", k, {8'h00, got[23:0]}, {8'h00, din[23:0]});
            chk("R2", k, {29'd0, got[31:29]} | {30'd0, got[25:24]}, 32'd0);
            chk("R3", k, {31'd0, got[27]}, {31'd0, par});
            if (fr >= 20 && fr <= 23)
                chk("R6", k, {31'd0, got[26]}, {31'd0, cs});
            else
                chk("R5", k, {31'd0, got[26]}, {31'd0, cs});
            if (k == 0)
                chk("R10", k, {31'd0, got[28]}, {31'd0, blk});
            else if (clamp_run)
                chk("R8", k, {31'd0, got[28]}, {31'd0, blk});
            else if (fr == 0)
                chk("R4", k, {31'd0, got[28]}, {31'd0, blk});
            else
                chk("R7", k, {31'd0, got[28]}, {31'd0, blk});
        end
    endtask

    // One stream: preload+flush via start, then stream nwords with backpressure
    task automatic run_stream(bit pre, int ncfg, int neff, logic [31:0] seed,
                              logic [31:0] salt, int unsigned nwords, int bp,
                              bit clamp_run);
        int unsigned tx;
        int unsigned rx;
        bit pend;
        bit extra;
        if (timed_out) return;
        // Preload a word that the start must discard
        @(negedge clk);
        s_valid_i = 1'b1;
        s_data_i  = 32'hDEAD_BEEF;
        m_ready_i = 1'b0;
        @(negedge clk);
        s_valid_i = 1'b0;
        start_i   = 1'b1;
        fmt_i     = pre;
        nch_i     = 4'(ncfg);
        cs_seed_i = seed;
        #1;
        chk("R10", 0, {31'd0, s_ready_o}, 32'd0);
        @(negedge clk);
        start_i   = 1'b0;
        // Scramble live configuration: must be ignored until next start
        rng       = next_rng(rng);
        fmt_i     = ~pre;
        nch_i     = rng[3:0];
        cs_seed_i = ~seed ^ rng;
        #1;
        chk("R10", 0, {31'd0, m_valid_o}, 32'd0);
        tx = 0;
        rx = 0;
        pend = 1'b0;
        while (rx < nwords && !timed_out) begin
            @(negedge clk);
            if (cyc > LIMIT) begin
                timed_out = 1'b1;
                break;
            end
            rng = next_rng(rng);
            if (!pend) begin
                if (tx < nwords && rng[1:0] != 2'b00) begin
                    s_valid_i = 1'b1;
                    s_data_i  = word_of(tx, salt);
                end else begin
                    s_valid_i = 1'b0;
                end
            end
            case (bp)
                0:       m_ready_i = 1'b1;
                1:       m_ready_i = rng[8];
                default: m_ready_i = (rng[10:9] == 2'b00);
            endcase
            #1;
            if (m_valid_o && m_ready_i) begin
                judge(pre, neff, seed, salt, rx, m_data_o, clamp_run);
                rx++;
            end
            if (s_valid_i && s_ready_o) begin
                tx++;
                pend = 1'b0;
            end else begin
                pend = s_valid_i;
            end
        end
        @(negedge clk);
        s_valid_i = 1'b0;
        m_ready_i = 1'b1;
        extra = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1;
            if (m_valid_o) extra = 1'b1;
            @(negedge clk);
        end
        chk("R11", rx, {31'd0, extra}, 32'd0);
        chk("R11", rx, tx, nwords);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R10", 0, {31'd0, m_valid_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        m_ready_i = 1'b1;
        #1;
        chk("R11", 0, {31'd0, s_ready_o}, 32'd1);

        for (int n = 2; n <= 8; n++) begin
            run_stream(1'b0, n, n, 32'hA5C3_0F96 ^ (n * 32'h0101_0107),
                       32'h0000_1000 * n, n * (2 * 192 + 3), n % 3, 1'b0);
        end
        run_stream(1'b0, 1, 2, 32'h5A5A_F00F, 32'h0BAD_0001, 2 * 200, 1, 1'b1);
        run_stream(1'b0, 0, 2, 32'hFFFF_FFFF, 32'h0BAD_0002, 2 * 40, 2, 1'b1);
        run_stream(1'b0, 15, 8, 32'h1357_9BDF, 32'h0BAD_0003, 8 * 196, 1, 1'b1);
        run_stream(1'b1, 4, 4, 32'h0000_0000, 32'h7E57_0004, 600, 1, 1'b0);
        run_stream(1'b1, 2, 2, 32'hFFFF_FFFF, 32'h7E57_0005, 300, 0, 1'b0);

        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule